// File: doc/BRIEF.md
# Falling-Edge SDA Delay Unit

This block sits in the outgoing data path of an I2C-style display data channel. It postpones the high-to-low transitions of SDA by a programmable time. Low-to-high transitions go straight through. The purpose is to push the SDA fall further away from the SCL fall when the two edges are too close together. SCL handling and the open-drain pad are outside the block.

The delay is made of two stages. A prescaler divides the 25 MHz reference clock (one 40 ns step per cycle) by `div + 1`. A tick counter then waits `cnt` prescaler ticks. The applied delay is therefore `cnt × (div + 1)` clock cycles, or `cnt × (div + 1) × 40 ns`, which spans 0 to 76800 ns. If SDA rises again before a pending delay runs out, the delay is dropped and the short low pulse never reaches the output.

The settings live in a 32-bit control word written with a masked-write convention. The upper half of each written word selects which bits of the lower half are actually updated.

Top module: `sda_fall_delay`

## Requirements
- R1: After reset the output is high and the stored configuration is all zero, so the delay is disabled: a low input then reaches the output after one clock edge.
- R2: On a write (`wr_en` = 1), stored bit n (0..15) takes `wr_data[n]` only when `wr_data[n+16]` is 1. Every other stored bit keeps its value. The stored fields are enable at bit 0, divider at bits 7:1 and count at bits 15:12.
- R3: When the enable bit is 0 or the count field is 0, `sda_out` equals `sda_in` delayed by one clock edge.
- R4: With enable = 1 and count ≠ 0, take the first edge that samples `sda_in` low after it was high. The output stays high through the following `count × (divider + 1) − 1` edges and goes low on the edge after them. That makes `count × (divider + 1) + 1` edges in total, counting the first one.
- R5: An edge that samples `sda_in` high drives `sda_out` high, whatever the settings.
- R6: If `sda_in` returns high while a falling-edge delay is pending, the delay is cancelled and `sda_out` never goes low for that pulse. A later fall starts a complete new delay.
- R7: The largest setting (count 15, divider 127) gives a delay of 1920 clock cycles, which is 76800 ns at the 40 ns step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz reference clock; one cycle is the 40 ns base step |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Bits 31:16 are the per-bit write mask; bits 15:0 are the data |
| sda_in | input | 1 | SDA value coming from the controller |
| sda_out | output | 1 | SDA value with delayed falling edges |

## Verification
A write takes effect on the clock edge that samples it, so the next stimulus can rely on it. A rising input, and any input while the delay is inactive, shows up on the output one edge after it is sampled. An enabled fall shows up `count × (divider + 1) + 1` edges after it is first sampled. The bench drives every input on the falling clock edge and samples the output on the falling edge. It counts the rising edges between dropping SDA and seeing the output low, then compares that count with the number it computes from the programmed count and divider. This is repeated over every count against the small dividers, and at the largest setting.

// File: rtl/sdly_pkg.sv
// Package: shared types for the falling-edge SDA delay unit.
// Holds the output state encoding used by the edge controller.
package sdly_pkg;

    // Output state: released high, high with a fall pending, driven low.
    typedef enum logic [1:0] {
        ST_HIGH = 2'd0,
        ST_HOLD = 2'd1,
        ST_LOW  = 2'd2
    } sdly_state_e;

endpackage

// File: rtl/sdly_ctrl_reg.sv
// Module: sdly_ctrl_reg
// Holds the lower half of the control word and updates it with a masked
// write: upper-half bit n+HALF_W enables the update of lower bit n.
// Assumes REG_W is even and that the field positions fit in the lower half.
module sdly_ctrl_reg #(
    parameter int REG_W   = 32,
    parameter int DIV_W   = 7,
    parameter int CNT_W   = 4,
    parameter int EN_POS  = 0,
    parameter int DIV_POS = 1,
    parameter int CNT_POS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             dly_en,
    output logic [DIV_W-1:0] dly_div,
    output logic [CNT_W-1:0] dly_cnt
);
    localparam int HALF_W = REG_W / 2;
    localparam logic [HALF_W-1:0] EN_MASK  = HALF_W'(1) << EN_POS;
    localparam logic [HALF_W-1:0] DIV_MASK = ((HALF_W'(1) << DIV_W) - HALF_W'(1)) << DIV_POS;
    localparam logic [HALF_W-1:0] CNT_MASK = ((HALF_W'(1) << CNT_W) - HALF_W'(1)) << CNT_POS;
    localparam logic [HALF_W-1:0] USED_MASK = EN_MASK | DIV_MASK | CNT_MASK;

    logic [HALF_W-1:0] hold_q;
    logic [HALF_W-1:0] wr_mask;
    logic [HALF_W-1:0] wr_val;
    logic              unused_spare;

    assign wr_mask = wr_data[REG_W-1:HALF_W];
    assign wr_val  = wr_data[HALF_W-1:0];

    // Merge the written value into the stored word, bit by bit under the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr_en) begin
            hold_q <= (hold_q & ~wr_mask) | (wr_val & wr_mask);
        end
    end

    // Break out the fields the delay path uses.
    always_comb begin
        dly_en  = hold_q[EN_POS];
        dly_div = hold_q[DIV_POS +: DIV_W];
        dly_cnt = hold_q[CNT_POS +: CNT_W];
    end

    // Spare bits are storage only and have no function.
    assign unused_spare = ^(hold_q & ~USED_MASK);

endmodule

// File: rtl/sdly_prescaler.sv
// Module: sdly_prescaler
// Divides the reference clock by (div + 1) while a delay runs.
// A load restarts the division; tick is high in the cycle the count is zero.
// Assumes load and run are never high together.
module sdly_prescaler #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] pre_q;

    // Count down from div and reload on reaching zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (load) begin
            pre_q <= div;
        end else if (run) begin
            pre_q <= (pre_q == '0) ? div : pre_q - DIV_W'(1);
        end
    end

    // One tick per (div + 1) running cycles.
    assign tick = run && (pre_q == '0);

endmodule

// File: rtl/sdly_edge_ctrl.sv
// Module: sdly_edge_ctrl
// Owns the SDA output. Rising input passes at once. A falling input is held
// for dly_cnt prescaler ticks when active, or passes in one cycle otherwise.
// A rise during the hold cancels it.
// Assumes the settings stay unchanged while a fall is pending.
module sdly_edge_ctrl
    import sdly_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_in,
    input  logic             active,
    input  logic [CNT_W-1:0] dly_cnt,
    input  logic             tick,
    output logic             load,
    output logic             run,
    output logic             pending,
    output logic             sda_out
);
    sdly_state_e      state_q, state_n;
    logic [CNT_W-1:0] ticks_q, ticks_n;

    // Next state and tick count from the input level and the settings.
    always_comb begin
        state_n = state_q;
        ticks_n = ticks_q;
        load    = 1'b0;
        if (!active) begin
            state_n = sda_in ? ST_HIGH : ST_LOW;
        end else if (sda_in) begin
            state_n = ST_HIGH;
        end else begin
            case (state_q)
                ST_HIGH: begin
                    state_n = ST_HOLD;
                    ticks_n = dly_cnt;
                    load    = 1'b1;
                end
                ST_HOLD: begin
                    if (tick) begin
                        if (ticks_q == CNT_W'(1)) begin
                            state_n = ST_LOW;
                        end else begin
                            ticks_n = ticks_q - CNT_W'(1);
                        end
                    end
                end
                default: state_n = ST_LOW;
            endcase
        end
    end

    // Register the state and the remaining ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HIGH;
            ticks_q <= '0;
        end else begin
            state_q <= state_n;
            ticks_q <= ticks_n;
        end
    end

    // Run the prescaler only while a fall is held and the input stays low.
    assign run     = active && !sda_in && (state_q == ST_HOLD);
    assign pending = (state_q == ST_HOLD);
    assign sda_out = (state_q != ST_LOW);

endmodule

// File: rtl/sda_fall_delay.sv
// Module: sda_fall_delay (top)
// Delays only the falling edges of SDA by cnt * (div + 1) reference cycles,
// with settings taken from a masked-write control word.
// Assumes one clock cycle is the 40 ns base step and inputs are synchronous.
module sda_fall_delay #(
    parameter int REG_W   = 32,
    parameter int DIV_W   = 7,
    parameter int CNT_W   = 4,
    parameter int EN_POS  = 0,
    parameter int DIV_POS = 1,
    parameter int CNT_POS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             sda_in,
    output logic             sda_out
);
    logic             dly_en;
    logic [DIV_W-1:0] dly_div;
    logic [CNT_W-1:0] dly_cnt;
    logic             active;
    logic             load;
    logic             run;
    logic             tick;
    logic             pending;

    sdly_ctrl_reg #(
        .REG_W  (REG_W),
        .DIV_W  (DIV_W),
        .CNT_W  (CNT_W),
        .EN_POS (EN_POS),
        .DIV_POS(DIV_POS),
        .CNT_POS(CNT_POS)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .dly_en (dly_en),
        .dly_div(dly_div),
        .dly_cnt(dly_cnt)
    );

    // The delay applies only when enabled with a nonzero count.
    assign active = dly_en && (dly_cnt != '0);

    sdly_prescaler #(
        .DIV_W(DIV_W)
    ) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .run  (run),
        .div  (dly_div),
        .tick (tick)
    );

    sdly_edge_ctrl #(
        .CNT_W(CNT_W)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sda_in (sda_in),
        .active (active),
        .dly_cnt(dly_cnt),
        .tick   (tick),
        .load   (load),
        .run    (run),
        .pending(pending),
        .sda_out(sda_out)
    );

endmodule

// File: rtl/sdly_chk.sv
// Module: sdly_chk
// Property checker bound to sda_fall_delay; observes ports and the
// internal enable, fields and pending flag. Drives nothing.
module sdly_chk #(
    parameter int REG_W = 32,
    parameter int DIV_W = 7,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic             sda_in,
    input logic             sda_out,
    input logic             active,
    input logic             pending,
    input logic             dly_en,
    input logic [DIV_W-1:0] dly_div,
    input logic [CNT_W-1:0] dly_cnt
);
    // R5
    rise_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_in |=> sda_out);

    // R3
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (sda_out == $past(sda_in)));

    // R6
    hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> sda_out);

    // R4
    fall_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_out) |-> !$past(sda_in));

    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[REG_W-1:REG_W/2] == '0)) |=> $stable({dly_en, dly_div, dly_cnt}));

endmodule

bind sda_fall_delay sdly_chk #(
    .REG_W(REG_W),
    .DIV_W(DIV_W),
    .CNT_W(CNT_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .sda_in (sda_in),
    .sda_out(sda_out),
    .active (active),
    .pending(pending),
    .dly_en (dly_en),
    .dly_div(dly_div),
    .dly_cnt(dly_cnt)
);

// File: tb/tb_sda_fall_delay.sv
// Bench for sda_fall_delay: sweeps count and small dividers, checks the
// largest setting, masked writes, cancellation and pass-through.
module tb_sda_fall_delay;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        sda_in = 1'b1;
    logic        sda_out;
    int          tests = 0;
    int          fails = 0;
    bit          done = 1'b0;

    sda_fall_delay dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .sda_in (sda_in),
        .sda_out(sda_out)
    );

    // 50 MHz bench clock.
    always #10 clk = ~clk;

    // Record one check and report it if it failed.
    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Full-mask control word: count at 15:12, divider at 7:1, enable at 0.
    function automatic logic [31:0] cfg(input int c, input int d, input int e);
        return {16'hFFFF, 4'(c), 4'b0000, 7'(d), 1'(e)};
    endfunction

    // Write one control word.
    task automatic write_reg(input logic [31:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    // Settle high, drop SDA and count edges until the output is low.
    task automatic measure_fall(output int lat);
        @(negedge clk);
        sda_in = 1'b1;
        repeat (3) @(negedge clk);
        sda_in = 1'b0;
        lat = 0;
        while (lat < 4000) begin
            @(negedge clk);
            lat++;
            if (!sda_out) break;
        end
    endtask

    // Raise SDA and check the output is high one edge later.
    task automatic check_rise(input string req);
        sda_in = 1'b1;
        @(negedge clk);
        check(sda_out == 1'b1, req, int'(sda_out), 1);
    endtask

    initial begin
        int lat;
        int lows;
        // R1: reset state.
        repeat (3) @(negedge clk);
        check(sda_out == 1'b1, "R1 reset output", int'(sda_out), 1);
        rst_n = 1'b1;
        measure_fall(lat);
        check(lat == 1, "R1 disabled after reset", lat, 1);
        check_rise("R5 rise after reset");

        // R4 sweep: every count against dividers 0..7.
        for (int c = 0; c < 16; c++) begin
            for (int d = 0; d < 8; d++) begin
                int exp;
                write_reg(cfg(c, d, 1));
                exp = (c == 0) ? 1 : c * (d + 1) + 1;
                measure_fall(lat);
                check(lat == exp, (c == 0) ? "R3 zero count" : "R4 fall delay", lat, exp);
                check_rise("R5 rise after delayed fall");
            end
        end

        // R3: enable clear with a large setting.
        write_reg(cfg(15, 7, 0));
        measure_fall(lat);
        check(lat == 1, "R3 enable clear", lat, 1);

        // R7: largest setting.
        write_reg(cfg(15, 127, 1));
        measure_fall(lat);
        check(lat == 1921, "R7 maximum delay", lat, 1921);
        check_rise("R5 rise after maximum");

        // R2: masked writes.
        write_reg(cfg(3, 1, 1));
        write_reg({16'h00FE, 4'd9, 4'd0, 7'd2, 1'b0});
        measure_fall(lat);
        check(lat == 10, "R2 divider only updated", lat, 10);
        write_reg(32'h0000_0000);
        measure_fall(lat);
        check(lat == 10, "R2 zero mask keeps all", lat, 10);
        write_reg(32'h0001_0000);
        measure_fall(lat);
        check(lat == 1, "R2 enable bit cleared alone", lat, 1);
        write_reg(32'h0001_0001);
        measure_fall(lat);
        check(lat == 10, "R2 enable bit set alone", lat, 10);

        // R6: short low pulse is absorbed, then a full delay follows.
        write_reg(cfg(4, 3, 1));
        @(negedge clk);
        sda_in = 1'b1;
        repeat (3) @(negedge clk);
        sda_in = 1'b0;
        lows = 0;
        repeat (10) begin
            @(negedge clk);
            if (!sda_out) lows++;
        end
        sda_in = 1'b1;
        repeat (5) begin
            @(negedge clk);
            if (!sda_out) lows++;
        end
        check(lows == 0, "R6 cancelled pulse", lows, 0);
        measure_fall(lat);
        check(lat == 17, "R6 full delay after cancel", lat, 17);
        check_rise("R5 final rise");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule